// File: doc/BRIEF.md
# Peak-Current-Mode PWM Timing Core

This block is the digital timing engine of a peak-current-mode switching regulator. A free-running counter divides the system clock into switching periods. The length of a period in clocks is set by an input word. Each period opens with the gate driver output asserted. The pulse then ends on whichever comes first: the peak-current comparator, the over-current comparator, or a duty ceiling of four fifths of the period. Both comparator inputs are ignored for a fixed number of clocks after the gate turns on, so that the switching edge cannot end the pulse falsely.

A soft-start level code, taken from an external converter that watches the soft-start capacitor, controls start-up. Below a lower breakpoint the gate stays off. Between the lower and upper breakpoints the duty ceiling scales linearly with the code. At or above the upper breakpoint the full ceiling applies. The captured soft-start level is held at zero while the controller is in reset or disabled. The block also produces a sawtooth code for an external slope-compensation DAC. This code climbs from zero across each period.

Top module: `cmpwm_core`

## Requirements
- R1: While `rst` is high, `gate` and `slope_code` are 0 on the next clock and stay 0, whatever the other inputs do.
- R2: Once `en` is sampled high, the switching period is P = max(`period_cyc`, MIN_PER) clocks. `gate` is asserted in the first clock of every period when the duty limit is non-zero.
- R3: With no comparator trip and the soft-start code at or above SS_HI, `gate` is high for exactly floor(4·P/5) clocks at the start of each period.
- R4: A comparator trip sampled while the in-period position is below BLANK_CYC (position 0 is the first clock of the period) has no effect on `gate`.
- R5: A `pwm_cmp` high sampled at in-period position k, with BLANK_CYC ≤ k < P−1, forces `gate` low from position k+1 to the end of that period.
- R6: An `ilim_cmp` high sampled at in-period position k, with BLANK_CYC ≤ k < P−1, forces `gate` low from position k+1 to the end of that period.
- R7: Cycle start loses to a trip. A trip on either comparator sampled at position P−1 keeps `gate` low for the whole following period.
- R8: With the soft-start code below SS_LO, `gate` never rises.
- R9: For SS_LO ≤ code < SS_HI, the on-time per period is floor(floor(4·P/5)·(code−SS_LO)/(SS_HI−SS_LO)) clocks.
- R10: At in-period position c, `slope_code` equals floor(c·SLOPE_AMP/P). It returns to 0 at each period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also holds the soft-start level at zero |
| en | input | 1 | Controller run enable; low stops switching and restarts the period |
| period_cyc | input | PER_W | Switching period in clocks (raised to MIN_PER if smaller) |
| pwm_cmp | input | 1 | Peak-current comparator flag, high = trip |
| ilim_cmp | input | 1 | Over-current comparator flag, high = trip |
| ss_level | input | SS_W | Soft-start level code |
| gate | output | 1 | Gate drive request |
| slope_code | output | SLOPE_W | Slope-compensation ramp code for an external DAC |

## Verification
The bench builds the core with 6-bit periods, MIN_PER = 8, BLANK_CYC = 3, a 5-bit soft-start code with breakpoints 4 and 20, and SLOPE_AMP = 6. With these values every period from the floor up to 20 clocks can be swept. So can all 32 soft-start codes and every trip position in a period, for both comparators separately. That covers the blanking edge, the reset-dominant period start and the clamped short period. Expected gate and ramp values for each clock come from the arithmetic of the requirements.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

    localparam int unsigned DUTY_NUM = 4;
    localparam int unsigned DUTY_DEN = 5;

    typedef struct packed {
        logic pwm;
        logic ilim;
    } trip_t;

    function automatic int unsigned eff_period(input int unsigned p, input int unsigned min_p);
        return (p < min_p) ? min_p : p;
    endfunction

    function automatic int unsigned max_on(input int unsigned p);
        return (p * DUTY_NUM) / DUTY_DEN;
    endfunction

    function automatic int unsigned duty_limit(input int unsigned ss, input int unsigned p,
                                               input int unsigned lo, input int unsigned hi);
        int unsigned full;
        full = max_on(p);
        if (ss < lo)
            return 0;
        else if (ss >= hi)
            return full;
        else
            return (full * (ss - lo)) / (hi - lo);
    endfunction

endpackage

// File: rtl/cmpwm_timer.sv
module cmpwm_timer #(
    parameter int PER_W   = 11,
    parameter int MIN_PER = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period_cyc,
    output logic [PER_W-1:0] per_eff,
    output logic [PER_W-1:0] cnt,
    output logic             run,
    output logic             start
);

    logic wrap;

    always_comb begin
        per_eff = PER_W'(cmpwm_pkg::eff_period(int'(period_cyc), MIN_PER));
        wrap    = (cnt >= per_eff - PER_W'(1));
        start   = run && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            run <= 1'b1;
            if (!run || wrap)
                cnt <= '0;
            else
                cnt <= cnt + PER_W'(1);
        end
    end

    // R2: a period start is followed by position zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == '0));

endmodule

// File: rtl/cmpwm_slope.sv
module cmpwm_slope #(
    parameter int PER_W     = 11,
    parameter int SLOPE_AMP = 28,
    parameter int SLOPE_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               start,
    input  logic [PER_W-1:0]   per_eff,
    output logic [SLOPE_W-1:0] slope_code
);

    logic [PER_W-1:0]   rem;
    logic [PER_W:0]     acc;
    logic [SLOPE_W-1:0] ramp;

    always_comb begin
        acc        = {1'b0, rem} + (PER_W+1)'(SLOPE_AMP);
        slope_code = run ? ramp : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !run || start) begin
            rem  <= '0;
            ramp <= '0;
        end else if (acc >= {1'b0, per_eff}) begin
            rem  <= PER_W'(acc - {1'b0, per_eff});
            ramp <= ramp + SLOPE_W'(1);
        end else begin
            rem  <= acc[PER_W-1:0];
        end
    end

    // R10: the ramp restarts at each period boundary
    a_r10_ramp_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (slope_code == '0));

    // R10: the ramp stays below its full amplitude
    a_r10_ramp_bound: assert property (@(posedge clk) disable iff (rst)
        int'(slope_code) < SLOPE_AMP);

endmodule

// File: rtl/cmpwm_pulse.sv
module cmpwm_pulse #(
    parameter int PER_W     = 11,
    parameter int SS_W      = 8,
    parameter int BLANK_CYC = 13,
    parameter int SS_LO     = 56,
    parameter int SS_HI     = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              run,
    input  logic              start,
    input  logic [PER_W-1:0]  cnt,
    input  logic [PER_W-1:0]  per_eff,
    input  cmpwm_pkg::trip_t  trips,
    input  logic [SS_W-1:0]   ss_level,
    output logic              gate
);

    logic [SS_W-1:0]  ss_q;
    logic [PER_W-1:0] lim;
    logic             term;
    logic             trip_any;
    logic             unblanked;

    always_comb begin
        trip_any  = trips.pwm | trips.ilim;
        unblanked = (cnt >= PER_W'(BLANK_CYC));
        lim       = PER_W'(cmpwm_pkg::duty_limit(int'(ss_q), int'(per_eff), SS_LO, SS_HI));
        gate      = run && !term && (cnt < lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            ss_q <= '0;
        else
            ss_q <= ss_level;
    end

    // pulse-ending latch: at a period start the trip wins over the set
    always_ff @(posedge clk) begin
        if (rst || !run)
            term <= 1'b0;
        else if (start)
            term <= trip_any;
        else if (trip_any && unblanked)
            term <= 1'b1;
    end

    // length of the current high run, used only by the duty check
    logic [PER_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst || !gate)
            hi_run <= '0;
        else
            hi_run <= hi_run + PER_W'(1);
    end

    // R3: the gate never stays high beyond four fifths of the period
    a_r3_duty_cap: assert property (@(posedge clk) disable iff (rst)
        gate |-> (int'(hi_run) < int'(cmpwm_pkg::max_on(int'(per_eff)))));

    // R5: an unblanked peak-current trip ends the pulse
    a_r5_pwm_end: assert property (@(posedge clk) disable iff (rst)
        (run && !start && trips.pwm && unblanked) |=> !gate);

    // R6: an unblanked over-current trip ends the pulse
    a_r6_ilim_end: assert property (@(posedge clk) disable iff (rst)
        (run && !start && trips.ilim && unblanked) |=> !gate);

    // R7: a trip coinciding with the period start keeps the gate off
    a_r7_reset_dominant: assert property (@(posedge clk) disable iff (rst)
        (start && trip_any) |=> !gate);

    // R8: below the soft-start low breakpoint the gate is off
    a_r8_ss_lockout: assert property (@(posedge clk) disable iff (rst)
        (int'(ss_q) < SS_LO) |-> !gate);

endmodule

// File: rtl/cmpwm_core.sv
module cmpwm_core #(
    parameter int PER_W     = 11,
    parameter int MIN_PER   = 250,
    parameter int BLANK_CYC = 13,
    parameter int SS_W      = 8,
    parameter int SS_LO     = 56,
    parameter int SS_HI     = 200,
    parameter int SLOPE_AMP = 28,
    localparam int SLOPE_W  = $clog2(SLOPE_AMP + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PER_W-1:0]   period_cyc,
    input  logic               pwm_cmp,
    input  logic               ilim_cmp,
    input  logic [SS_W-1:0]    ss_level,
    output logic               gate,
    output logic [SLOPE_W-1:0] slope_code
);

    logic [PER_W-1:0] per_eff;
    logic [PER_W-1:0] cnt;
    logic             run;
    logic             start;
    cmpwm_pkg::trip_t trips;

    always_comb begin
        trips.pwm  = pwm_cmp;
        trips.ilim = ilim_cmp;
    end

    cmpwm_timer #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_timer (
        .clk(clk), .rst(rst), .en(en), .period_cyc(period_cyc),
        .per_eff(per_eff), .cnt(cnt), .run(run), .start(start)
    );

    cmpwm_pulse #(.PER_W(PER_W), .SS_W(SS_W), .BLANK_CYC(BLANK_CYC),
                  .SS_LO(SS_LO), .SS_HI(SS_HI)) u_pulse (
        .clk(clk), .rst(rst), .en(en), .run(run), .start(start), .cnt(cnt),
        .per_eff(per_eff), .trips(trips), .ss_level(ss_level), .gate(gate)
    );

    cmpwm_slope #(.PER_W(PER_W), .SLOPE_AMP(SLOPE_AMP), .SLOPE_W(SLOPE_W)) u_slope (
        .clk(clk), .rst(rst), .run(run), .start(start), .per_eff(per_eff),
        .slope_code(slope_code)
    );

endmodule

// File: tb/test_cmpwm_core.sv
`timescale 1ns/1ps
module test_cmpwm_core;

    localparam int PER_W = 6;
    localparam int MINP  = 8;
    localparam int BLANK = 3;
    localparam int SS_W  = 5;
    localparam int LO    = 4;
    localparam int HI    = 20;
    localparam int AMP   = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [PER_W-1:0] period_cyc = 6'd10;
    logic             pwm_cmp = 1'b0;
    logic             ilim_cmp = 1'b0;
    logic [SS_W-1:0]  ss_level = '0;
    logic             gate;
    logic [2:0]       slope_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmpwm_core #(.PER_W(PER_W), .MIN_PER(MINP), .BLANK_CYC(BLANK), .SS_W(SS_W),
                 .SS_LO(LO), .SS_HI(HI), .SLOPE_AMP(AMP)) i_cmpwm_core (
        .clk(clk), .rst(rst), .en(en), .period_cyc(period_cyc), .pwm_cmp(pwm_cmp),
        .ilim_cmp(ilim_cmp), .ss_level(ss_level), .gate(gate), .slope_code(slope_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int on_len(input int p, input int ss);
        int full;
        full = (p * 4) / 5;
        if (ss < LO) return 0;
        if (ss >= HI) return full;
        return (full * (ss - LO)) / (HI - LO);
    endfunction

    // sel: 0 none, 1 peak-current comparator, 2 over-current comparator
    task automatic run_case(input int per_in, input int ss, input int trip_at,
                            input int sel, input string tag, input int ncyc);
        int p;
        int lim;
        bit term;
        bit tr;
        p   = (per_in < MINP) ? MINP : per_in;
        lim = on_len(p, ss);
        @(negedge clk);
        period_cyc = PER_W'(per_in);
        ss_level   = SS_W'(ss);
        en         = 1'b1;
        term       = 1'b0;
        for (int i = 0; i < ncyc * p; i++) begin
            int c;
            @(negedge clk);
            c = i % p;
            check(tag, int'(gate), int'((c < lim) && !term));
            check("R10", int'(slope_code), (c * AMP) / p);
            tr       = (sel != 0) && (c == trip_at);
            pwm_cmp  = tr && (sel == 1);
            ilim_cmp = tr && (sel == 2);
            if (c == p - 1) term = tr;
            else if (tr && c >= BLANK) term = 1'b1;
        end
        @(negedge clk);
        pwm_cmp  = 1'b0;
        ilim_cmp = 1'b0;
        en       = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int p;
        string tg;
        ss_level = 5'd31;
        en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(gate), 0);
        check("R1", int'(slope_code), 0);
        rst = 1'b0;
        en  = 1'b0;
        repeat (2) @(negedge clk);

        // R2, R3, R10: full soft-start across periods, including clamped short ones
        run_case(3, 31, -1, 0, "R2", 2);
        for (int pp = MINP; pp <= 20; pp++) run_case(pp, 31, -1, 0, "R3", 3);

        // R8, R9: every soft-start code at a fixed period
        for (int s = 0; s < 32; s++)
            run_case(15, s, -1, 0, (s < LO) ? "R8" : "R9", 2);

        // R4..R7: every trip position for each comparator
        p = 12;
        for (int k = 0; k < p; k++) begin
            tg = (k < BLANK) ? "R4" : ((k == p - 1) ? "R7" : "R5");
            run_case(p, 31, k, 1, tg, 3);
            tg = (k < BLANK) ? "R4" : ((k == p - 1) ? "R7" : "R6");
            run_case(p, 31, k, 2, tg, 3);
        end
        // R4 with a short on-time: trips at position 0 under soft-start
        run_case(MINP, 12, 0, 1, "R4", 3);

        // R1: reset while enabled and switching
        @(negedge clk);
        period_cyc = 6'd10;
        ss_level = 5'd31;
        en = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R1", int'(gate), 0);
            check("R1", int'(slope_code), 0);
        end
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule